// File: doc/BRIEF.md
# Gate Drive Command and Desaturation Fault Controller

This block is the clocked control logic for one isolated gate-drive channel. It turns a pair of command inputs, one non-inverting and one inverting, into a single gate-on command. Short glitches on both command inputs and on an active-low enable input are rejected. The drive request is true only when the non-inverting input is high and the inverting input is low. This allows two uses: toggle the positive input with the negative one tied low, or toggle the negative input with the positive one tied high.

A desaturation comparator flag arrives as a digital level. The block looks at it only while the gate is on and only after a leading-edge blanking interval from each turn-on. The flag must then stay high for a filter time before a fault is latched. A latched fault, a lockout input or a qualified low on the enable input holds the gate off. The enable input does two jobs that depend on how long it is low. Any qualified low disables the output. A low that lasts at least a fault-clear time also clears the latched fault, and the clear takes effect on the release edge. The fault output is active low.

All asynchronous inputs pass through two-flop synchronizers. All time thresholds are parameters counted in clock cycles. The defaults are 4 cycles for the glitch filter, 80 for the clear time, 40 for blanking and 25 for the desaturation filter.

Top module: `gdrv_desat_ctrl`

## Requirements
- R1: After its inputs settle, `gate_on_o` is 1 exactly when `cmd_pos_i`=1, `cmd_neg_i`=0, `en_n_i`=1, `uvlo_i`=0 and no fault is latched. Otherwise it is 0.
- R2: A level on `cmd_pos_i` or `cmd_neg_i` held for fewer than GLITCH_CYC (4) clock cycles has no effect on `gate_on_o`. A level held for GLITCH_CYC cycles is passed on. A 4-cycle pulse gives a 4-cycle change of `gate_on_o`.
- R3: A low on `en_n_i` that lasts GLITCH_CYC cycles or more forces `gate_on_o` to 0. A low shorter than GLITCH_CYC cycles has no effect.
- R4: A latched fault is cleared when `en_n_i` is released after being low for at least CLEAR_CYC (80) consecutive cycles. A low of CLEAR_CYC-1 cycles leaves the fault latched.
- R5: `desat_i` is ignored while the gate is off and for the first BLANK_CYC (40) cycles after each turn-on. With `desat_i` already high at turn-on, the gate stays on for exactly BLANK_CYC+FILT_CYC cycles.
- R6: After blanking, `desat_i` must be high for FILT_CYC (25) consecutive cycles to latch a fault. A high pulse of FILT_CYC-1 cycles latches nothing.
- R7: While a fault is latched or `uvlo_i`=1, `gate_on_o` is 0 whatever the command inputs are. `uvlo_i` leaves the fault state unchanged.
- R8: `gate_on_o` falls in the same cycle the fault latch sets. `fault_n_o` goes to 0 one cycle later.
- R9: A synchronous reset (`rst`=1) gives `gate_on_o`=0 and `fault_n_o`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_pos_i | input | 1 | Non-inverting command, asynchronous |
| cmd_neg_i | input | 1 | Inverting command, asynchronous |
| en_n_i | input | 1 | Active-low disable and fault-clear input, asynchronous |
| uvlo_i | input | 1 | Undervoltage lockout flag, 1 = locked out |
| desat_i | input | 1 | Desaturation comparator flag, 1 = collector voltage too high |
| gate_on_o | output | 1 | Gate-on command to the output stage |
| fault_n_o | output | 1 | Desaturation fault, active low |

## Verification
The hardest states to reach from the ports are the exact timing boundaries. The blanking and filter windows only count while the gate is on. The stimulus therefore raises `desat_i` while the gate is off and then turns the gate on. It counts the cycles the gate stays on, which should be the sum of the two windows, and it records which cycle each of the two outputs falls. It then produces pulses one cycle short of the filter time and exactly at it. It also drives enable lows of 79 and 80 cycles through the glitch filter to find the clear boundary. Random command, enable and lockout patterns are then checked against a reference function once the inputs settle.

// File: rtl/gdrv_pkg.sv
package gdrv_pkg;
    localparam int unsigned DEF_SYNC_STAGES = 2;
    localparam int unsigned DEF_GLITCH_CYC  = 4;
    localparam int unsigned DEF_CLEAR_CYC   = 80;
    localparam int unsigned DEF_BLANK_CYC   = 40;
    localparam int unsigned DEF_FILT_CYC    = 25;

    // synchronized input bit positions
    localparam int unsigned IDX_POS   = 0;
    localparam int unsigned IDX_NEG   = 1;
    localparam int unsigned IDX_EN    = 2;
    localparam int unsigned IDX_DESAT = 3;
    localparam int unsigned IDX_UVLO  = 4;
    localparam int unsigned N_INPUTS  = 5;
    localparam int unsigned N_FILTERED = 3;

    // idle levels: positive low, negative high, enable high (inactive)
    localparam logic [N_INPUTS-1:0] IDLE_LEVELS = 5'b00110;

    typedef struct packed {
        logic gate;
        logic fault_n;
    } drive_state_t;
endpackage

// File: rtl/gdrv_sync.sv
module gdrv_sync #(
    parameter int unsigned WIDTH  = 1,
    parameter int unsigned STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) stage_q[g] <= RST_VAL;
                else     stage_q[g] <= stage_d[g];
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/gdrv_glitch_filter.sv
module gdrv_glitch_filter #(
    parameter int unsigned HOLD_CYC = 4,
    parameter logic        INIT     = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic in_i,
    output logic out_o
);
    localparam int unsigned CW = (HOLD_CYC < 2) ? 1 : $clog2(HOLD_CYC);
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

    typedef struct packed {
        logic          out;
        logic [CW-1:0] cnt;
    } filt_state_t;

    filt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (in_i != st_q.out) begin
            if (st_q.cnt == LAST) begin
                st_d.out = in_i;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.out <= INIT;
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_o = st_q.out;

    // R2 / R3: the filtered level only moves after a full hold window
    p_filter_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (st_q.out != $past(st_q.out)) |-> ($past(st_q.cnt) == LAST));
endmodule

// File: rtl/gdrv_desat_guard.sv
module gdrv_desat_guard #(
    parameter int unsigned BLANK_CYC = 40,
    parameter int unsigned FILT_CYC  = 25,
    parameter int unsigned CLEAR_CYC = 80
) (
    input  logic clk,
    input  logic rst,
    input  logic gate_i,
    input  logic desat_i,
    input  logic en_i,
    output logic fault_set_o,
    output logic fault_o
);
    localparam int unsigned BW = $clog2(BLANK_CYC + 1) < 1 ? 1 : $clog2(BLANK_CYC + 1);
    localparam int unsigned FW = $clog2(FILT_CYC + 1)  < 1 ? 1 : $clog2(FILT_CYC + 1);
    localparam int unsigned LW = $clog2(CLEAR_CYC + 1) < 1 ? 1 : $clog2(CLEAR_CYC + 1);
    localparam logic [BW-1:0] BLANK_END = BW'(BLANK_CYC);
    localparam logic [FW-1:0] FILT_LAST = FW'(FILT_CYC - 1);
    localparam logic [LW-1:0] CLEAR_LIM = LW'(CLEAR_CYC);

    typedef struct packed {
        logic [BW-1:0] blank;
        logic [FW-1:0] filt;
        logic [LW-1:0] low;
        logic          fault;
    } guard_state_t;

    guard_state_t st_d, st_q;
    logic armed, trip, release_edge, long_release;

    always_comb begin
        st_d         = st_q;
        armed        = gate_i && (st_q.blank == BLANK_END);
        trip         = armed && desat_i && (st_q.filt == FILT_LAST) && !st_q.fault;
        release_edge = en_i && (st_q.low != '0);
        long_release = release_edge && (st_q.low == CLEAR_LIM);

        // leading-edge blanking since the last turn-on
        if (!gate_i) begin
            st_d.blank = '0;
        end else if (st_q.blank != BLANK_END) begin
            st_d.blank = st_q.blank + 1'b1;
        end

        // consecutive qualified desaturation cycles
        if (armed && desat_i && (st_q.filt != FILT_LAST)) begin
            st_d.filt = st_q.filt + 1'b1;
        end else begin
            st_d.filt = '0;
        end

        // length of the current enable low, saturating
        if (!en_i) begin
            if (st_q.low != CLEAR_LIM) st_d.low = st_q.low + 1'b1;
        end else begin
            st_d.low = '0;
        end

        if (trip) begin
            st_d.fault = 1'b1;
        end else if (long_release) begin
            st_d.fault = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign fault_set_o = trip;
    assign fault_o     = st_q.fault;

    // R5: a fault only latches while the gate was on
    p_fault_only_on_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q.fault) |-> $past(gate_i));

    // R6: a fault only latches on an asserted sense flag
    p_fault_needs_flag_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q.fault) |-> $past(desat_i));

    // R4: a fault clears only on the release edge of the enable input
    p_clear_on_release_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(st_q.fault) |-> ($past(en_i) && !$past(en_i, 2)));
endmodule

// File: rtl/gdrv_desat_ctrl.sv
module gdrv_desat_ctrl
    import gdrv_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES,
    parameter int unsigned GLITCH_CYC  = DEF_GLITCH_CYC,
    parameter int unsigned CLEAR_CYC   = DEF_CLEAR_CYC,
    parameter int unsigned BLANK_CYC   = DEF_BLANK_CYC,
    parameter int unsigned FILT_CYC    = DEF_FILT_CYC
) (
    input  logic clk,
    input  logic rst,
    input  logic cmd_pos_i,
    input  logic cmd_neg_i,
    input  logic en_n_i,
    input  logic uvlo_i,
    input  logic desat_i,
    output logic gate_on_o,
    output logic fault_n_o
);
    logic [N_INPUTS-1:0]   raw_in, sync_in;
    logic [N_FILTERED-1:0] filt_in;
    logic req, en_ok, uvlo_s, desat_s, fault, fault_set;
    drive_state_t st_d, st_q;

    assign raw_in[IDX_POS]   = cmd_pos_i;
    assign raw_in[IDX_NEG]   = cmd_neg_i;
    assign raw_in[IDX_EN]    = en_n_i;
    assign raw_in[IDX_DESAT] = desat_i;
    assign raw_in[IDX_UVLO]  = uvlo_i;

    gdrv_sync #(
        .WIDTH   (N_INPUTS),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (IDLE_LEVELS)
    ) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (raw_in),
        .sync_o  (sync_in)
    );

    generate
        for (genvar g = 0; g < N_FILTERED; g++) begin : g_filt
            gdrv_glitch_filter #(
                .HOLD_CYC (GLITCH_CYC),
                .INIT     (IDLE_LEVELS[g])
            ) u_filt (
                .clk   (clk),
                .rst   (rst),
                .in_i  (sync_in[g]),
                .out_o (filt_in[g])
            );
        end
    endgenerate

    assign req     = filt_in[IDX_POS] && !filt_in[IDX_NEG];
    assign en_ok   = filt_in[IDX_EN];
    assign desat_s = sync_in[IDX_DESAT];
    assign uvlo_s  = sync_in[IDX_UVLO];

    gdrv_desat_guard #(
        .BLANK_CYC (BLANK_CYC),
        .FILT_CYC  (FILT_CYC),
        .CLEAR_CYC (CLEAR_CYC)
    ) u_guard (
        .clk         (clk),
        .rst         (rst),
        .gate_i      (st_q.gate),
        .desat_i     (desat_s),
        .en_i        (en_ok),
        .fault_set_o (fault_set),
        .fault_o     (fault)
    );

    always_comb begin
        st_d         = st_q;
        st_d.gate    = req && en_ok && !uvlo_s && !fault && !fault_set;
        st_d.fault_n = !fault;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.gate    <= 1'b0;
            st_q.fault_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign gate_on_o = st_q.gate;
    assign fault_n_o = st_q.fault_n;

    // R1: the gate only turns on after a drive request
    p_gate_needs_req_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q.gate) |-> $past(req));

    // R3: a qualified disable turns the gate off
    p_disable_blocks_r3: assert property (@(posedge clk) disable iff (rst)
        !en_ok |=> !st_q.gate);

    // R7: latched fault and lockout hold the gate off
    p_fault_blocks_r7: assert property (@(posedge clk) disable iff (rst)
        fault |-> !st_q.gate);
    p_uvlo_blocks_r7: assert property (@(posedge clk) disable iff (rst)
        uvlo_s |=> !st_q.gate);

    // R8: gate drops with the latch, fault output follows one cycle later
    p_gate_drops_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(fault) |-> (!st_q.gate && $past(st_q.gate)));
    p_fault_out_lag_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(fault) |=> !fault_n_o);
endmodule

// File: tb/gdrv_desat_ctrl_bench.sv
module gdrv_desat_ctrl_bench;
    localparam int unsigned BLANK = 40;
    localparam int unsigned FILT  = 25;
    localparam int unsigned CLEAR = 80;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmd_pos = 1'b0, cmd_neg = 1'b0, en_n = 1'b1, uvlo = 1'b0, desat = 1'b0;
    logic gate_on, fault_n;
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    always #4 clk = ~clk;

    gdrv_desat_ctrl u_gdrv_desat_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cmd_pos_i (cmd_pos),
        .cmd_neg_i (cmd_neg),
        .en_n_i    (en_n),
        .uvlo_i    (uvlo),
        .desat_i   (desat),
        .gate_on_o (gate_on),
        .fault_n_o (fault_n)
    );

    function automatic logic exp_gate(logic p, logic n, logic e, logic u, logic f);
        return p && !n && e && !u && !f;
    endfunction

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic count_high(int n, output int highs);
        highs = 0;
        for (int i = 0; i < n; i++) begin
            tick(1);
            if (gate_on) highs++;
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        int h;
        int seed;
        seed = $urandom(32'h5eed);
        tick(5);
        chk(gate_on, 0, "R9 reset gate");
        chk(fault_n, 1, "R9 reset fault_n");
        rst = 1'b0;
        tick(10);
        chk(gate_on, 0, "R9 idle after reset");

        // non-inverting mode
        cmd_pos = 1'b1; tick(20);
        chk(gate_on, 1, "R1 pos high neg low");
        cmd_pos = 1'b0; tick(20);
        chk(gate_on, 0, "R1 pos low");
        // inverting mode
        cmd_pos = 1'b1; cmd_neg = 1'b1; tick(20);
        chk(gate_on, 0, "R1 both high");
        cmd_neg = 1'b0; tick(20);
        chk(gate_on, 1, "R1 inverting on");
        cmd_neg = 1'b1; tick(20);
        chk(gate_on, 0, "R1 inverting off");
        cmd_pos = 1'b0; cmd_neg = 1'b0; tick(20);
        chk(gate_on, 0, "R1 both low");

        // glitch rejection on the command inputs
        cmd_pos = 1'b1; tick(3); cmd_pos = 1'b0;
        count_high(20, h);
        chk(h, 0, "R2 3-cycle pos pulse suppressed");
        cmd_pos = 1'b1; tick(4); cmd_pos = 1'b0;
        count_high(20, h);
        chk(h, 4, "R2 4-cycle pos pulse passed");
        cmd_pos = 1'b1; tick(20);
        cmd_neg = 1'b1; tick(3); cmd_neg = 1'b0;
        count_high(20, h);
        chk(h, 20, "R2 3-cycle neg pulse suppressed");

        // enable input
        en_n = 1'b0; tick(3); en_n = 1'b1;
        count_high(20, h);
        chk(h, 20, "R3 3-cycle enable low suppressed");
        en_n = 1'b0; tick(9);
        chk(gate_on, 0, "R3 qualified disable");
        en_n = 1'b1; tick(20);
        chk(gate_on, 1, "R3 re-enabled");

        // lockout
        uvlo = 1'b1; tick(5);
        chk(gate_on, 0, "R7 lockout forces off");
        chk(fault_n, 1, "R7 lockout leaves fault clear");
        uvlo = 1'b0; tick(5);
        chk(gate_on, 1, "R7 lockout released");

        // desaturation present at turn-on
        cmd_pos = 1'b0; tick(20);
        desat = 1'b1; tick(100);
        chk(fault_n, 1, "R5 flag ignored while off");
        cmd_pos = 1'b1;
        begin
            int on_cyc = 0, gate_fall = -1, flt_fall = -1;
            logic prev_gate = 1'b0;
            for (int i = 0; i < 150; i++) begin
                tick(1);
                if (gate_on) on_cyc++;
                if (prev_gate && !gate_on && gate_fall < 0) gate_fall = i;
                if (!fault_n && flt_fall < 0) flt_fall = i;
                prev_gate = gate_on;
            end
            chk(on_cyc, BLANK + FILT, "R5 on-time equals blank plus filter");
            chk(flt_fall - gate_fall, 1, "R8 fault output one cycle after gate off");
        end
        desat = 1'b0; tick(20);
        chk(gate_on, 0, "R7 fault holds gate off");
        chk(fault_n, 0, "R7 fault latched");

        // fault clear boundary
        en_n = 1'b0; tick(CLEAR - 1); en_n = 1'b1; tick(20);
        chk(fault_n, 0, "R4 79-cycle low keeps fault");
        chk(gate_on, 0, "R4 gate still off");
        en_n = 1'b0; tick(CLEAR); en_n = 1'b1; tick(20);
        chk(fault_n, 1, "R4 80-cycle low clears fault");
        chk(gate_on, 1, "R4 gate resumes");

        // desaturation filter boundary
        tick(60);
        desat = 1'b1; tick(FILT - 1); desat = 1'b0; tick(10);
        chk(fault_n, 1, "R6 24-cycle flag no fault");
        chk(gate_on, 1, "R6 gate stays on");
        desat = 1'b1; tick(FILT); desat = 1'b0; tick(10);
        chk(fault_n, 0, "R6 25-cycle flag latches fault");
        chk(gate_on, 0, "R6 gate off after fault");
        en_n = 1'b0; tick(90); en_n = 1'b1; tick(20);
        chk(fault_n, 1, "R4 cleared again");

        // random command, enable and lockout patterns
        for (int k = 0; k < 200; k++) begin
            int hold;
            cmd_pos = 1'($urandom_range(1, 0));
            cmd_neg = 1'($urandom_range(1, 0));
            en_n    = ($urandom_range(3, 0) != 0);
            uvlo    = ($urandom_range(7, 0) == 0);
            hold    = int'($urandom_range(40, 12));
            tick(hold);
            chk(gate_on, exp_gate(cmd_pos, cmd_neg, en_n, uvlo, 1'b0), "R1 random pattern");
        end
        chk(fault_n, 1, "R7 no fault from random patterns");

        done = 1'b1;
        summary();
        $finish;
    end
endmodule